// File: doc/BRIEF.md
# Downward-Addressed Framebuffer Scan-Out with Fixed Palette

This engine reads a 100 by 100 frame of 4-bit colour indices out of a 64 KiB byte-addressed memory and turns it into a stream of 24-bit RGB pixels. The framebuffer occupies the top of the address space. Its first byte is at 0xFFFF, and each following byte is one address lower. Every byte carries two pixels. The engine fetches each byte once, splits it into its two indices and maps each index through a fixed 16-colour table.

A frame is started by a one-cycle `frameTick` pulse, which is normally generated 60 times per second by the display timing. The engine then walks all 5000 bytes in raster order: left to right along a row, then down to the next row. It issues one read on the shared memory port every two cycles, and the port answers one cycle after each request. Pixels leave at one per clock. Each pixel carries a valid flag, a start-of-frame mark and an end-of-line mark. Ticks that arrive while a frame is in progress are dropped.

Top module: `fbScanout`

## Requirements
- R1: After reset `memReq`, `pixValid`, `pixSof`, `pixEol` and `busy` are all low, and no read is issued until a tick arrives.
- R2: A `frameTick` seen while idle produces a read request with `memAddr` = 0xFFFF in the next cycle. Each further request is one address lower, and the frame ends after exactly 5000 requests, the last at 0xEC78.
- R3: Bits 7:4 of a byte give the earlier (left) pixel and bits 3:0 give the pixel right after it.
- R4: Index values 0 to 15 map to RGB 1a1c2c, 5d275d, b13e53, ef7d57, ffcd75, a7f070, 38b764, 257179, 29366f, 3b5dc9, 41a6f6, 73eff7, f4f4f4, 94b0c2, 566c86, 333c57 in that order.
- R5: The read port returns data in the cycle after a request, and a pixel's colour comes only from the byte returned for its own request. Bus contents in other cycles have no effect.
- R6: `pixSof` is high on the first pixel of a frame (row 0, column 0) and on no other pixel.
- R7: `pixEol` is high on column 99 of every row, which gives exactly 100 marks per frame, and on no other pixel.
- R8: A frame delivers exactly 10000 pixels with `pixValid` high on consecutive cycles from the first to the last. `busy` returns low when the frame completes.
- R9: A `frameTick` while `busy` is high is ignored. The running frame keeps its address sequence and pixel count, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle frame start request |
| memReq | output | 1 | Byte read request |
| memAddr | output | 16 | Byte address of the request |
| memData | input | 8 | Read data, valid the cycle after `memReq` |
| busy | output | 1 | Frame scan in progress |
| pixValid | output | 1 | Pixel output valid |
| pixRgb | output | 24 | Pixel colour, R in bits 23:16 |
| pixSof | output | 1 | First pixel of the frame |
| pixEol | output | 1 | Last pixel of a row |

## Verification
Most internal faults show up within one frame. A wrong address counter shows at `memAddr` on the first request after the tick or at the final address 0xEC78. A wrong nibble order or palette entry corrupts `pixRgb` from the very first pixel. Column or row counters that drift show as a misplaced `pixEol` within the first 100 pixels, or as a second `pixSof`. A state machine that restarts on a stray tick is caught at the frame's end, because the request and pixel totals no longer match 5000 and 10000.

// File: rtl/scanPkg.sv
package scanPkg;

  localparam int PIX_BITS = 4;
  localparam int BYTE_W = 8;
  localparam int RGB_W = 24;
  localparam int PIX_PER_BYTE = BYTE_W / PIX_BITS;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_HIGH,
    S_LOW
  } scanState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic start;    // clear counters for a new frame
    logic fetch;    // issue a byte read this cycle
    logic capture;  // read data is on the bus: latch it, emit left pixel
    logic emitLow;  // emit right pixel from the held byte
  } scanStrobe_t;

  function automatic logic [RGB_W-1:0] paletteColor(input logic [PIX_BITS-1:0] idx);
    logic [RGB_W-1:0] rgb;
    case (idx)
      4'h0: rgb = 24'h1a1c2c;
      4'h1: rgb = 24'h5d275d;
      4'h2: rgb = 24'hb13e53;
      4'h3: rgb = 24'hef7d57;
      4'h4: rgb = 24'hffcd75;
      4'h5: rgb = 24'ha7f070;
      4'h6: rgb = 24'h38b764;
      4'h7: rgb = 24'h257179;
      4'h8: rgb = 24'h29366f;
      4'h9: rgb = 24'h3b5dc9;
      4'hA: rgb = 24'h41a6f6;
      4'hB: rgb = 24'h73eff7;
      4'hC: rgb = 24'hf4f4f4;
      4'hD: rgb = 24'h94b0c2;
      4'hE: rgb = 24'h566c86;
      default: rgb = 24'h333c57;
    endcase
    return rgb;
  endfunction

endpackage

// File: rtl/paletteLut.sv
module paletteLut
  import scanPkg::*;
(
  input  logic [PIX_BITS-1:0] colorIdx,
  output logic [RGB_W-1:0]    colorRgb
);

  always_comb colorRgb = paletteColor(colorIdx);

endmodule

// File: rtl/scanControl.sv
module scanControl
  import scanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        moreBytes,
  output scanStrobe_t stb,
  output logic        busy
);

  scanState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (frameTick) begin
          stb.start = 1'b1;
          stateD = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        stateD = S_HIGH;
      end
      S_HIGH: begin
        stb.capture = 1'b1;
        stateD = S_LOW;
      end
      S_LOW: begin
        stb.emitLow = 1'b1;
        if (moreBytes) begin
          stb.fetch = 1'b1;   // overlap next read with the right pixel
          stateD = S_HIGH;
        end else begin
          stateD = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != S_IDLE);

  // a tick during a scan must not restart the walk
  assert_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE && frameTick) |=> (stateQ != S_FETCH));

  // a capture is always followed by the right pixel of the same byte
  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> stb.emitLow);

endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import scanPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 65535,
  parameter int COLS     = 100,
  parameter int ROWS     = 100
)(
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       stb,
  input  logic [BYTE_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              moreBytes,
  output logic              pixValid,
  output logic [RGB_W-1:0]  pixRgb,
  output logic              pixSof,
  output logic              pixEol
);

  localparam int PIXELS = COLS * ROWS;
  localparam int BYTES  = PIXELS / PIX_PER_BYTE;
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS + 1);
  localparam int CNT_W  = $clog2(BYTES + 1);
  localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(TOP_ADDR);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(TOP_ADDR - BYTES + 1);

  logic [ADDR_W-1:0] nextAddrQ;
  logic [CNT_W-1:0]  fetchCntQ;
  logic [BYTE_W-1:0] byteQ;
  logic [COL_W-1:0]  colQ;
  logic [ROW_W-1:0]  rowQ;
  logic [PIX_BITS-1:0] pixIdx;
  logic [RGB_W-1:0]  lutRgb;
  logic              emitting;
  logic              atLastCol;

  // read port
  assign memReq    = stb.fetch;
  assign memAddr   = nextAddrQ;
  assign moreBytes = (fetchCntQ != CNT_W'(BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddrQ <= FIRST_ADDR;
      fetchCntQ <= '0;
    end else if (stb.start) begin
      nextAddrQ <= FIRST_ADDR;
      fetchCntQ <= '0;
    end else if (stb.fetch) begin
      nextAddrQ <= nextAddrQ - 1'b1;   // framebuffer grows downward
      fetchCntQ <= fetchCntQ + 1'b1;
    end
  end

  // byte hold: left pixel is taken straight off the bus, right pixel later
  always_ff @(posedge clk) begin
    if (!rstN)            byteQ <= '0;
    else if (stb.capture) byteQ <= memData;
  end

  assign emitting = stb.capture | stb.emitLow;
  assign pixIdx   = stb.capture ? memData[BYTE_W-1 -: PIX_BITS]
                                : byteQ[PIX_BITS-1:0];

  paletteLut lut (
    .colorIdx (pixIdx),
    .colorRgb (lutRgb)
  );

  // raster position
  assign atLastCol = (colQ == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (!rstN || stb.start) begin
      colQ <= '0;
      rowQ <= '0;
    end else if (emitting) begin
      if (atLastCol) begin
        colQ <= '0;
        rowQ <= rowQ + 1'b1;
      end else begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  // registered pixel output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixRgb   <= '0;
      pixSof   <= 1'b0;
      pixEol   <= 1'b0;
    end else begin
      pixValid <= emitting;
      pixRgb   <= emitting ? lutRgb : '0;
      pixSof   <= emitting && colQ == '0 && rowQ == '0;
      pixEol   <= emitting && atLastCol;
    end
  end

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr <= FIRST_ADDR && memAddr >= LAST_ADDR));

  assert_capture_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> $past(memReq));

  assert_single_sof_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixSof |=> !pixSof);

  assert_eol_on_pixel_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixEol |-> pixValid);

  assert_no_stream_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture) |=> (pixValid && stb.emitLow));

endmodule

// File: rtl/fbScanout.sv
module fbScanout
  import scanPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TOP_ADDR = 65535,
  parameter int COLS     = 100,
  parameter int ROWS     = 100
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memData,
  output logic              busy,
  output logic              pixValid,
  output logic [RGB_W-1:0]  pixRgb,
  output logic              pixSof,
  output logic              pixEol
);

  scanStrobe_t stb;
  logic        moreBytes;

  scanControl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .moreBytes (moreBytes),
    .stb       (stb),
    .busy      (busy)
  );

  scanDatapath #(
    .ADDR_W   (ADDR_W),
    .TOP_ADDR (TOP_ADDR),
    .COLS     (COLS),
    .ROWS     (ROWS)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .memData   (memData),
    .memReq    (memReq),
    .memAddr   (memAddr),
    .moreBytes (moreBytes),
    .pixValid  (pixValid),
    .pixRgb    (pixRgb),
    .pixSof    (pixSof),
    .pixEol    (pixEol)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/fbScanout_test.sv
`timescale 1ns/1ps
module fbScanout_test;

  localparam int NBYTES = 5000;
  localparam int NPIX   = 10000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic        memReq;
  logic [15:0] memAddr;
  logic [7:0]  memData = 8'h00;
  logic        busy;
  logic        pixValid;
  logic [23:0] pixRgb;
  logic        pixSof;
  logic        pixEol;

  always #2 clk = ~clk;

  fbScanout uut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .busy(busy), .pixValid(pixValid), .pixRgb(pixRgb),
    .pixSof(pixSof), .pixEol(pixEol)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] fb [0:NBYTES-1];

  function automatic logic [23:0] refRgb(input logic [3:0] i);
    logic [23:0] t [16] = '{24'h1a1c2c, 24'h5d275d, 24'hb13e53, 24'hef7d57,
                            24'hffcd75, 24'ha7f070, 24'h38b764, 24'h257179,
                            24'h29366f, 24'h3b5dc9, 24'h41a6f6, 24'h73eff7,
                            24'hf4f4f4, 24'h94b0c2, 24'h566c86, 24'h333c57};
    return t[i];
  endfunction

  // memory model: one-cycle latency, junk on idle cycles (R5)
  always @(posedge clk) begin
    if (memReq && (32'hFFFF - 32'(memAddr)) < NBYTES)
      memData <= fb[32'hFFFF - 32'(memAddr)];
    else
      memData <= 8'hA5;
  end

  // frame monitor
  int readCount, pixCount, addrErr, rgbErr, sofErr, eolErr, gapErr;
  int sofCount, eolCount;
  logic [15:0] firstAddr, lastAddr, badAddrAct, badAddrExp;
  logic [23:0] badRgbAct, badRgbExp;
  logic [23:0] firstPix [2];

  task automatic clearMon();
    readCount = 0; pixCount = 0; addrErr = 0; rgbErr = 0; sofErr = 0;
    eolErr = 0; gapErr = 0; sofCount = 0; eolCount = 0;
    firstAddr = 0; lastAddr = 0; badAddrAct = 0; badAddrExp = 0;
    badRgbAct = 0; badRgbExp = 0; firstPix[0] = 0; firstPix[1] = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) begin
        if (readCount == 0) firstAddr = memAddr;
        lastAddr = memAddr;
        if (memAddr != 16'(32'hFFFF - readCount)) begin
          if (addrErr == 0) begin
            badAddrAct = memAddr; badAddrExp = 16'(32'hFFFF - readCount);
          end
          addrErr++;
        end
        readCount++;
      end
      if (pixValid) begin
        logic [7:0] b;
        logic [3:0] nib;
        logic [23:0] exp;
        b   = (pixCount / 2 < NBYTES) ? fb[pixCount / 2] : 8'h00;
        nib = (pixCount % 2 == 0) ? b[7:4] : b[3:0];
        exp = refRgb(nib);
        if (pixRgb != exp) begin
          if (rgbErr == 0) begin badRgbAct = pixRgb; badRgbExp = exp; end
          rgbErr++;
        end
        if (pixSof != (pixCount == 0)) sofErr++;
        if (pixSof) sofCount++;
        if (pixEol != (pixCount % 100 == 99)) eolErr++;
        if (pixEol) eolCount++;
        if (pixCount < 2) firstPix[pixCount] = pixRgb;
        pixCount++;
      end else if (pixCount > 0 && pixCount < NPIX) begin
        gapErr++;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseTick();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 30000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // start a frame, check the first request, run it to the end
  task automatic runFrame();
    @(negedge clk) clearMon();
    frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
    check("R2", "first request after tick", {memReq, memAddr}, {1'b1, 16'hFFFF});
    waitIdle();
  endtask

  task automatic checkFrame(input string tag);
    check("R2", {tag, " read count"}, readCount, NBYTES);
    check("R2", {tag, " address order"}, badAddrAct, badAddrExp);
    check("R2", {tag, " last address"}, lastAddr, 16'hEC78);
    check("R8", {tag, " pixel count"}, pixCount, NPIX);
    check("R8", {tag, " stream gaps"}, gapErr, 0);
    check("R8", {tag, " busy low at end"}, busy, 0);
    check("R6", {tag, " sof count"}, sofCount, 1);
    check("R6", {tag, " sof placement"}, sofErr, 0);
    check("R7", {tag, " eol count"}, eolCount, 100);
    check("R7", {tag, " eol placement"}, eolErr, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "outputs after reset", {memReq, pixValid, pixSof, pixEol, busy}, 0);
  endtask

  task automatic testRamp();
    for (int i = 0; i < NBYTES; i++) fb[i] = {4'(i), 4'(i + 7)};
    runFrame();
    checkFrame("ramp");
    check("R4", "ramp palette colours", badRgbAct, badRgbExp);
    check("R4", "ramp colour mismatches", rgbErr, 0);
  endtask

  task automatic testNibbleOrder();
    for (int i = 0; i < NBYTES; i++) fb[i] = 8'h6E;
    fb[0] = 8'h2C;
    runFrame();
    check("R3", "left pixel from bits 7:4", firstPix[0], 24'hb13e53);
    check("R3", "right pixel from bits 3:0", firstPix[1], 24'hf4f4f4);
    check("R3", "nibble split mismatches", rgbErr, 0);
  endtask

  task automatic testRandom();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NBYTES; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fb[i] = lfsr[7:0];
    end
    runFrame();
    checkFrame("random");
    check("R5", "colour only from returned byte", badRgbAct, badRgbExp);
    check("R5", "random colour mismatches", rgbErr, 0);
  endtask

  task automatic testTickIgnored();
    for (int i = 0; i < NBYTES; i++) fb[i] = 8'(i * 13 + 5);
    @(negedge clk) clearMon();
    frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
    repeat (3000) @(negedge clk);
    pulseTick();
    repeat (2500) @(negedge clk);
    pulseTick();
    pulseTick();
    waitIdle();
    check("R9", "reads with mid-frame ticks", readCount, NBYTES);
    check("R9", "pixels with mid-frame ticks", pixCount, NPIX);
    check("R9", "address order kept", badAddrAct, badAddrExp);
    check("R9", "sof count", sofCount, 1);
    check("R9", "colours kept", rgbErr, 0);
    repeat (20) @(negedge clk);
    check("R9", "no second frame", readCount, NBYTES);
    check("R1", "idle after frame", {memReq, busy}, 0);
  endtask

  task automatic testBackToBack();
    for (int i = 0; i < NBYTES; i++) fb[i] = (i % 2 == 0) ? 8'hF0 : 8'h0F;
    runFrame();
    checkFrame("back-to-back");
    check("R4", "alternating colours", rgbErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearMon();
    for (int i = 0; i < NBYTES; i++) fb[i] = 8'h00;
    testReset();
    testRamp();
    testNibbleOrder();
    testRandom();
    testTickIgnored();
    testBackToBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule